// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps wall-clock time from a one-pulse-per-second tick. Seconds and minutes run from 00 to 59 and hours from 00 to 23, all in packed BCD (tens digit in the upper nibble, ones digit in the lower nibble). Each field carries into the next when it wraps. Above the hours sits a plain binary day count of 15 bits. Software reaches everything through an 8-bit register port with byte addresses: a write strobe with address and data, and a read that is purely combinational from the address.

An alarm compares the minute, hour and day against programmed values. Each of the three comparisons has its own enable. When the alarm fires it sets a sticky flag, and software clears that flag by writing a 1 to it. An interrupt output follows the flag, gated by an enable bit. A read-only busy bit is high in the cycle that an increment is applied. Software polls it before touching a time field.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every time field, every alarm register and the control register read 0, and `irq_o` is low.
- R2: On a clock edge with `tick_i` high and the run bit (control bit 0) set, the seconds advance by one. With the run bit clear, a tick changes no field.
- R3: Fields count in BCD. A ones digit of 9 carries into the tens digit. Seconds 59 and minutes 59 wrap to 00 and advance the next field. Hours 23 wrap to 00 and advance the day.
- R4: The day count is binary and 15 bits wide. Address 0x18 holds bits 7:0 and address 0x19 holds bits 14:8. Bit 7 of 0x19 reads 0, and writing it has no effect. The count wraps from 0x7FFF to 0.
- R5: Control bit 7 reads 1 while `tick_i` is high and the run bit is set, and 0 otherwise. Writing bit 7 has no effect.
- R6: A write to a time field in the same cycle as an applied tick stores the written value in that field instead of its increment.
- R7: The alarm flag (control bit 2) sets on an applied tick that takes the seconds to 00, provided that every enabled comparison matches the new time. The enables are control bit 3 for the minute, bit 4 for the hour and bit 5 for the day. A disabled comparison is ignored. A tick that does not roll the seconds never sets the flag.
- R8: With bits 3, 4 and 5 all clear, the alarm flag never sets, even when all the alarm registers match.
- R9: Writing 1 to control bit 2 clears the alarm flag. Writing 0 there leaves the flag unchanged.
- R10: `irq_o` is high exactly while the alarm flag and the interrupt enable (control bit 1) are both set.
- R11: The registers are at these addresses: control 0x14, seconds 0x15, minutes 0x16, hours 0x17, day 0x18/0x19, alarm minute 0x1A, alarm hour 0x1B, alarm day 0x1C/0x1D. Control bits 0, 1, 3, 4 and 5 read back as written. Control bit 6 and any unmapped address read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt request |

## Verification
A write, or an applied tick, lands on the clock edge that samples it, and reads are combinational. Every field, the flag and `irq_o` therefore hold their new values one edge after the stimulus. The busy bit is the exception: it is valid during the tick cycle itself. The bench drives its inputs on the falling edge. It samples one nanosecond after the next falling edge for registered results. For the busy bit it samples one nanosecond after the falling edge that raises the tick. Alarm checks read the control register right after the rolling tick, and read it again after each write to the flag.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam logic [7:0] A_CTRL   = 8'h14;
  localparam logic [7:0] A_SEC    = 8'h15;
  localparam logic [7:0] A_MIN    = 8'h16;
  localparam logic [7:0] A_HOUR   = 8'h17;
  localparam logic [7:0] A_DAY_LO = 8'h18;
  localparam logic [7:0] A_DAY_HI = 8'h19;
  localparam logic [7:0] A_AMIN   = 8'h1A;
  localparam logic [7:0] A_AHOUR  = 8'h1B;
  localparam logic [7:0] A_ADAY_LO = 8'h1C;
  localparam logic [7:0] A_ADAY_HI = 8'h1D;

  localparam int unsigned MS_TENS_W = 3;  // minutes/seconds tens digit
  localparam int unsigned HR_TENS_W = 2;  // hours tens digit
  localparam int unsigned MS_W = MS_TENS_W + 4;
  localparam int unsigned HR_W = HR_TENS_W + 4;

  typedef struct packed {
    logic day_en;
    logic hour_en;
    logic min_en;
    logic flag;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int unsigned TENS_W   = 3,
  parameter int unsigned MAX_TENS = 5,
  parameter int unsigned MAX_ONES = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              ld_i,
  input  logic [TENS_W+3:0] ld_val_i,
  output logic [TENS_W+3:0] val_o,
  output logic [TENS_W+3:0] nxt_o,
  output logic              wrap_o
);
  localparam int unsigned W = TENS_W + 4;
  localparam logic [W-1:0] MAXV = {TENS_W'(MAX_TENS), 4'(MAX_ONES)};

  logic [W-1:0] val_q, inc_val;
  logic [TENS_W-1:0] tens;
  logic [3:0] ones;

  assign tens = val_q[W-1:4];
  assign ones = val_q[3:0];

  always_comb begin
    if (val_q == MAXV)      inc_val = '0;
    else if (ones == 4'd9)  inc_val = {tens + TENS_W'(1), 4'd0};
    else                    inc_val = {tens, ones + 4'd1};
  end

  assign wrap_o = inc_i && (val_q == MAXV);
  assign nxt_o  = ld_i ? ld_val_i : (inc_i ? inc_val : val_q);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= nxt_o;
  end

  // R3
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && val_q == MAXV) |=> (val_q == '0));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_day_count.sv
module rtc_day_count #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_lo_i,
  input  logic         ld_hi_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] nxt_o
);
  localparam int unsigned HI_W = W - 8;

  logic [W-1:0] val_q;

  always_comb begin
    nxt_o = inc_i ? val_q + W'(1) : val_q;
    if (ld_lo_i) nxt_o[7:0]   = wdata_i;
    if (ld_hi_i) nxt_o[W-1:8] = wdata_i[HI_W-1:0];
  end

  assign val_o = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= nxt_o;
  end

  // R4
  day_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_lo_i && !ld_hi_i && val_q == {W{1'b1}}) |=> (val_q == '0));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned MIN_W = 7,
  parameter int unsigned HR_W  = 6,
  parameter int unsigned DAY_W = 15
) (
  input  logic             roll_i,
  input  logic             min_en_i,
  input  logic             hour_en_i,
  input  logic             day_en_i,
  input  logic [MIN_W-1:0] min_i,
  input  logic [HR_W-1:0]  hour_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [MIN_W-1:0] amin_i,
  input  logic [HR_W-1:0]  ahour_i,
  input  logic [DAY_W-1:0] aday_i,
  output logic             hit_o
);
  logic min_ok, hour_ok, day_ok, any_en;

  assign min_ok  = !min_en_i  || (min_i  == amin_i);
  assign hour_ok = !hour_en_i || (hour_i == ahour_i);
  assign day_ok  = !day_en_i  || (day_i  == aday_i);
  assign any_en  = min_en_i || hour_en_i || day_en_i;
  assign hit_o   = roll_i && any_en && min_ok && hour_ok && day_ok;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int unsigned DAY_W = 15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  ctrl_t ctrl_q;
  logic step, busy;
  logic ld_sec, ld_min, ld_hour, ld_day_lo, ld_day_hi, wr_ctrl;
  logic sec_wrap, min_wrap, hour_wrap, hit;
  logic [MS_W-1:0] sec, sec_nxt, min, min_nxt, amin_q;
  logic [HR_W-1:0] hour, hour_nxt, ahour_q;
  logic [DAY_W-1:0] day, day_nxt, aday_q;

  assign step = tick_i && ctrl_q.run;
  assign busy = step;

  assign wr_ctrl   = wr_i && (addr_i == A_CTRL);
  assign ld_sec    = wr_i && (addr_i == A_SEC);
  assign ld_min    = wr_i && (addr_i == A_MIN);
  assign ld_hour   = wr_i && (addr_i == A_HOUR);
  assign ld_day_lo = wr_i && (addr_i == A_DAY_LO);
  assign ld_day_hi = wr_i && (addr_i == A_DAY_HI);

  rtc_bcd_field #(.TENS_W(MS_TENS_W), .MAX_TENS(5), .MAX_ONES(9)) u_sec (
    .clk_i, .rst_ni, .inc_i(step), .ld_i(ld_sec), .ld_val_i(wdata_i[MS_W-1:0]),
    .val_o(sec), .nxt_o(sec_nxt), .wrap_o(sec_wrap));

  rtc_bcd_field #(.TENS_W(MS_TENS_W), .MAX_TENS(5), .MAX_ONES(9)) u_min (
    .clk_i, .rst_ni, .inc_i(sec_wrap), .ld_i(ld_min), .ld_val_i(wdata_i[MS_W-1:0]),
    .val_o(min), .nxt_o(min_nxt), .wrap_o(min_wrap));

  rtc_bcd_field #(.TENS_W(HR_TENS_W), .MAX_TENS(2), .MAX_ONES(3)) u_hour (
    .clk_i, .rst_ni, .inc_i(min_wrap), .ld_i(ld_hour), .ld_val_i(wdata_i[HR_W-1:0]),
    .val_o(hour), .nxt_o(hour_nxt), .wrap_o(hour_wrap));

  rtc_day_count #(.W(DAY_W)) u_day (
    .clk_i, .rst_ni, .inc_i(hour_wrap), .ld_lo_i(ld_day_lo), .ld_hi_i(ld_day_hi),
    .wdata_i, .val_o(day), .nxt_o(day_nxt));

  // compare against the time that the rolling tick produces
  rtc_alarm_cmp #(.MIN_W(MS_W), .HR_W(HR_W), .DAY_W(DAY_W)) u_alarm (
    .roll_i(sec_wrap && !ld_sec),
    .min_en_i(ctrl_q.min_en), .hour_en_i(ctrl_q.hour_en), .day_en_i(ctrl_q.day_en),
    .min_i(min_nxt), .hour_i(hour_nxt), .day_i(day_nxt),
    .amin_i(amin_q), .ahour_i(ahour_q), .aday_i(aday_q),
    .hit_o(hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
      aday_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.run     <= wdata_i[0];
        ctrl_q.irq_en  <= wdata_i[1];
        ctrl_q.min_en  <= wdata_i[3];
        ctrl_q.hour_en <= wdata_i[4];
        ctrl_q.day_en  <= wdata_i[5];
      end
      if (hit)                       ctrl_q.flag <= 1'b1;
      else if (wr_ctrl && wdata_i[2]) ctrl_q.flag <= 1'b0;
      if (wr_i && addr_i == A_AMIN)    amin_q  <= wdata_i[MS_W-1:0];
      if (wr_i && addr_i == A_AHOUR)   ahour_q <= wdata_i[HR_W-1:0];
      if (wr_i && addr_i == A_ADAY_LO) aday_q[7:0] <= wdata_i;
      if (wr_i && addr_i == A_ADAY_HI) aday_q[DAY_W-1:8] <= wdata_i[DAY_W-9:0];
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:    rdata_o = {busy, 1'b0, ctrl_q.day_en, ctrl_q.hour_en, ctrl_q.min_en,
                            ctrl_q.flag, ctrl_q.irq_en, ctrl_q.run};
      A_SEC:     rdata_o = 8'(sec);
      A_MIN:     rdata_o = 8'(min);
      A_HOUR:    rdata_o = 8'(hour);
      A_DAY_LO:  rdata_o = day[7:0];
      A_DAY_HI:  rdata_o = 8'(day[DAY_W-1:8]);
      A_AMIN:    rdata_o = 8'(amin_q);
      A_AHOUR:   rdata_o = 8'(ahour_q);
      A_ADAY_LO: rdata_o = aday_q[7:0];
      A_ADAY_HI: rdata_o = 8'(aday_q[DAY_W-1:8]);
      default:   rdata_o = 8'h00;
    endcase
  end

  assign irq_o = ctrl_q.flag && ctrl_q.irq_en;

  // R7
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q.flag) |-> $past(tick_i && ctrl_q.run));

  // R8
  no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_q.min_en || ctrl_q.hour_en || ctrl_q.day_en) |=> !$rose(ctrl_q.flag));

  // R9
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && wdata_i[2] && !hit) |=> !ctrl_q.flag);

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.irq_en |-> !irq_o);
endmodule

// File: tb/rtc_calendar_test.sv
`timescale 1ns/1ps
module rtc_calendar_test;
  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic irq_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_calendar uut (.clk_i(clk), .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i, .rdata_o, .irq_o);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr_i = a; #1;
    check(req, rdata_o, exp);
  endtask

  task automatic tick();
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] dhi, input logic [7:0] dlo);
    wr(8'h17, h); wr(8'h16, m); wr(8'h15, s); wr(8'h19, dhi); wr(8'h18, dlo);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 8'h14, 8'h00);
    rd_chk("R1 sec", 8'h15, 8'h00);
    rd_chk("R1 day_hi", 8'h19, 8'h00);
    rd_chk("R1 amin", 8'h1A, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rd_chk("R11 unmapped", 8'h20, 8'h00);
  endtask

  task automatic t_run();
    wr(8'h15, 8'h30);
    tick();
    rd_chk("R2 stopped", 8'h15, 8'h30);
    wr(8'h14, 8'h01);
    tick();
    rd_chk("R2 advance", 8'h15, 8'h31);
    wr(8'h14, 8'h7B);
    rd_chk("R11 ctrl readback", 8'h14, 8'h3B);
    wr(8'h14, 8'h01);
  endtask

  task automatic t_busy();
    @(negedge clk); tick_i = 1'b1; addr_i = 8'h14; #1;
    check("R5 busy high", rdata_o, 8'h81);
    @(negedge clk); tick_i = 1'b0; #1;
    check("R5 busy low", rdata_o, 8'h01);
    wr(8'h14, 8'h81);
    rd_chk("R5 busy not writable", 8'h14, 8'h01);
  endtask

  task automatic t_carry();
    wr(8'h15, 8'h09);
    tick();
    rd_chk("R3 ones carry", 8'h15, 8'h10);
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h05);
    tick();
    rd_chk("R3 sec wrap", 8'h15, 8'h00);
    rd_chk("R3 min wrap", 8'h16, 8'h00);
    rd_chk("R3 hour wrap", 8'h17, 8'h00);
    rd_chk("R3 day lo", 8'h18, 8'h06);
    rd_chk("R3 day hi", 8'h19, 8'h01);
    set_time(8'h09, 8'h59, 8'h59, 8'h00, 8'h00);
    tick();
    rd_chk("R3 hour ones carry", 8'h17, 8'h10);
  endtask

  task automatic t_day_wrap();
    set_time(8'h23, 8'h59, 8'h59, 8'hFF, 8'hFF);
    rd_chk("R4 high bit7 ignored", 8'h19, 8'h7F);
    tick();
    rd_chk("R4 wrap lo", 8'h18, 8'h00);
    rd_chk("R4 wrap hi", 8'h19, 8'h00);
  endtask

  task automatic t_override();
    wr(8'h15, 8'h30);
    @(negedge clk); tick_i = 1'b1; wr_i = 1'b1; addr_i = 8'h15; wdata_i = 8'h12;
    @(negedge clk); tick_i = 1'b0; wr_i = 1'b0;
    rd_chk("R6 write wins", 8'h15, 8'h12);
  endtask

  task automatic t_alarm();
    wr(8'h1A, 8'h05); wr(8'h1B, 8'h10); wr(8'h1C, 8'h00); wr(8'h1D, 8'h00);
    set_time(8'h10, 8'h04, 8'h59, 8'h00, 8'h00);
    wr(8'h14, 8'h09);
    tick();
    rd_chk("R7 minute match", 8'h14, 8'h0D);
    check("R10 irq masked", {7'd0, irq_o}, 8'h00);
    wr(8'h14, 8'h0B);
    rd_chk("R9 zero keeps flag", 8'h14, 8'h0F);
    check("R10 irq high", {7'd0, irq_o}, 8'h01);
    wr(8'h14, 8'h0F);
    rd_chk("R9 w1c", 8'h14, 8'h0B);
    check("R10 irq low", {7'd0, irq_o}, 8'h00);
    tick();
    rd_chk("R7 no roll", 8'h14, 8'h0B);
    wr(8'h1B, 8'h11);
    wr(8'h14, 8'h19);
    wr(8'h15, 8'h59); wr(8'h16, 8'h04);
    tick();
    rd_chk("R7 hour mismatch", 8'h14, 8'h19);
    wr(8'h1B, 8'h10); wr(8'h1C, 8'h03); wr(8'h1D, 8'h02);
    set_time(8'h10, 8'h04, 8'h59, 8'h02, 8'h03);
    wr(8'h14, 8'h39);
    tick();
    rd_chk("R7 all match", 8'h14, 8'h3D);
    wr(8'h14, 8'h3D);
    rd_chk("R9 clear again", 8'h14, 8'h39);
  endtask

  task automatic t_no_en();
    wr(8'h1A, 8'h00); wr(8'h1B, 8'h00); wr(8'h1C, 8'h00); wr(8'h1D, 8'h00);
    wr(8'h14, 8'h03);
    set_time(8'h23, 8'h59, 8'h59, 8'h7F, 8'hFF);
    tick();
    rd_chk("R8 no enables", 8'h14, 8'h03);
    check("R8 irq", {7'd0, irq_o}, 8'h00);
  endtask

  initial begin : watchdog
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_run();
    t_busy();
    t_carry();
    t_day_wrap();
    t_override();
    t_alarm();
    t_no_en();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule